// File: doc/BRIEF.md
# SPI Error Flag Monitor

This block runs next to an SPI shift engine and watches two error conditions: a mode fault on the slave-select line and a receive overflow. It brings the slave-select pin in through a two-stage synchroniser. It then judges that line by the current role. A slave reports a fault when the line rises while a transfer is under way. A master reports a fault whenever the line is low. An enable bit gates both cases. The block also holds the receive data register. It flags an overflow when a complete byte arrives while the previous byte is still unread. In that case it keeps the older byte and drops the new one.

Both flags are sticky. Software clears a flag in two steps. First it reads the status while the flag is set. Later it makes the matching access: a control write clears the mode fault, and a data read clears the overflow. One error-interrupt enable gates both flags onto a single registered interrupt request. The two enables are written through a control port and read back in the status word, next to the two flags.

Top module: `spi_fault_watch`

## Requirements
- R1: After synchronous reset, the mode-fault flag, the overflow flag, the interrupt request, both enables and the receive data register are all 0.
- R2: The slave-select pin passes through two flip-flops before it is evaluated. A qualifying pin change made before clock edge k sets the mode-fault flag at edge k+2, and the flag is visible from then on.
- R3: In slave role (role_i = 0), with the fault enable set, a rising slave-select sets the mode-fault flag only while xfer_busy_i is high. A rise while idle, or a fall, leaves the flag at 0.
- R4: In master role (role_i = 1), with the fault enable set, a synchronised low slave-select sets the mode-fault flag whatever the state of xfer_busy_i. The flag stays set after the line returns high.
- R5: With the fault enable at 0, neither role sets the mode-fault flag.
- R6: A byte-complete strobe that arrives while the receive data register holds an unread byte, with no data read in the same cycle, sets the overflow flag. The register keeps the older byte.
- R7: A byte-complete strobe and a data read in the same cycle count as read-then-load. The new byte is loaded and no overflow is raised.
- R8: The mode-fault flag clears only on a control write made after a status read that saw the flag set. A control write with no prior status read leaves it set.
- R9: The overflow flag clears only on a data read made after a status read that saw the flag set. A data read alone leaves it set.
- R10: err_irq_o is registered. It equals the interrupt enable AND (mode fault OR overflow), as those stood one clock earlier.
- R11: Field layout: ctl_wdata_i bit 0 is the fault enable and bit 1 is the interrupt enable. stat_o bit 0 is the fault enable, bit 1 the interrupt enable, bit 2 the mode-fault flag and bit 3 the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_i | input | 1 | 1 = master, 0 = slave |
| ssel_pin_i | input | 1 | Asynchronous slave-select pin level |
| xfer_busy_i | input | 1 | Transfer in progress |
| byte_done_i | input | 1 | Shift register holds a complete byte (one-cycle strobe) |
| rx_byte_i | input | DW | Byte from the shift register |
| data_rd_i | input | 1 | Receive data register read strobe |
| stat_rd_i | input | 1 | Status read strobe |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 2 | Control write data (enables) |
| stat_o | output | 4 | Status word: flags and enables |
| rx_data_o | output | DW | Receive data register |
| mode_fault_o | output | 1 | Sticky mode-fault flag |
| overflow_o | output | 1 | Sticky overflow flag |
| err_irq_o | output | 1 | Registered error interrupt request |

## Verification
The assertions check the following every cycle:
- A slave-role fault never appears without a transfer in progress.
- A master sees its flag set after a low line.
- No fault arises while the fault enable is off.
- Both flags hold unless their clear handshake completes.
- An overflowing byte leaves the data register unchanged.
- A same-cycle read and load never raises an overflow.
- The interrupt stays low one cycle after the enable was low.

Only the bench scenarios can show the rest:
- The exact three-edge latency through the synchroniser.
- That an idle rise or a falling line is ignored.
- The ordering in the two-step clear handshakes.
- The field positions in the status word.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;

    localparam int unsigned SYNC_STAGES = 2;
    localparam int unsigned CTL_W       = 2;
    localparam int unsigned STAT_W      = 4;

    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    // control word: bit1 interrupt enable, bit0 fault enable
    typedef struct packed {
        logic irq_en;
        logic mf_en;
    } ctl_t;

    // status word: bit3 overflow, bit2 mode fault, bits1:0 control
    typedef struct packed {
        logic ovf;
        logic mf;
        ctl_t ctl;
    } stat_t;

    function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
    parameter int unsigned STAGES = spi_fault_pkg::SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], pin_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = chain[STAGES-1] & ~prev;

endmodule

// File: rtl/mode_fault_det.sv
module mode_fault_det
    import spi_fault_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic role_i,
    input  logic mf_en_i,
    input  logic busy_i,
    input  logic ss_level_i,
    input  logic ss_rise_i,
    input  logic stat_rd_i,
    input  logic ctl_wr_i,
    output logic mf_o
);
    logic mf_q;
    logic arm_q;
    logic fault_evt;
    logic clr_go;

    always_comb begin
        fault_evt = 1'b0;
        if (mf_en_i) begin
            if (role_i == ROLE_MASTER) fault_evt = ~ss_level_i;
            else                       fault_evt = busy_i & ss_rise_i;
        end
    end

    assign clr_go = ctl_wr_i & arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mf_q  <= 1'b0;
            arm_q <= 1'b0;
        end else begin
            mf_q <= sticky_next(mf_q, fault_evt, clr_go);
            if (clr_go)                arm_q <= 1'b0;
            else if (stat_rd_i && mf_q) arm_q <= 1'b1;
        end
    end

    assign mf_o = mf_q;

    p_slave_needs_busy_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(mf_q) && !$past(role_i)) |-> $past(busy_i));

    p_master_low_r4: assert property (@(posedge clk) disable iff (rst)
        (mf_en_i && role_i && !ss_level_i) |=> mf_q);

    p_no_fault_disabled_r5: assert property (@(posedge clk) disable iff (rst)
        (!mf_en_i && !mf_q) |=> !mf_q);

    p_mf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (mf_q && !(ctl_wr_i && arm_q)) |=> mf_q);

endmodule

// File: rtl/rx_overflow_det.sv
module rx_overflow_det
    import spi_fault_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          byte_done_i,
    input  logic [DW-1:0] rx_byte_i,
    input  logic          data_rd_i,
    input  logic          stat_rd_i,
    output logic [DW-1:0] rx_data_o,
    output logic          ovf_o
);
    logic [DW-1:0] data_q;
    logic          full_q;
    logic          ovf_q;
    logic          arm_q;
    logic          load;
    logic          ovf_evt;
    logic          clr_go;

    assign load    = byte_done_i & (~full_q | data_rd_i);
    assign ovf_evt = byte_done_i & full_q & ~data_rd_i;
    assign clr_go  = data_rd_i & arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            full_q <= 1'b0;
            ovf_q  <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            if (load) data_q <= rx_byte_i;
            full_q <= load | (full_q & ~data_rd_i);
            ovf_q  <= sticky_next(ovf_q, ovf_evt, clr_go);
            if (clr_go)                  arm_q <= 1'b0;
            else if (stat_rd_i && ovf_q) arm_q <= 1'b1;
        end
    end

    assign rx_data_o = data_q;
    assign ovf_o     = ovf_q;

    p_keep_old_r6: assert property (@(posedge clk) disable iff (rst)
        (byte_done_i && full_q && !data_rd_i) |=> ($stable(data_q) && ovf_q));

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (byte_done_i && data_rd_i && !ovf_q) |=> !ovf_q);

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !(data_rd_i && arm_q)) |=> ovf_q);

endmodule

// File: rtl/spi_fault_watch.sv
module spi_fault_watch
    import spi_fault_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              role_i,
    input  logic              ssel_pin_i,
    input  logic              xfer_busy_i,
    input  logic              byte_done_i,
    input  logic [DW-1:0]     rx_byte_i,
    input  logic              data_rd_i,
    input  logic              stat_rd_i,
    input  logic              ctl_wr_i,
    input  logic [CTL_W-1:0]  ctl_wdata_i,
    output logic [STAT_W-1:0] stat_o,
    output logic [DW-1:0]     rx_data_o,
    output logic              mode_fault_o,
    output logic              overflow_o,
    output logic              err_irq_o
);
    ctl_t  ctl_q;
    stat_t stat;
    logic  ss_level;
    logic  ss_rise;
    logic  mf;
    logic  ovf;
    logic  irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (ctl_wr_i) ctl_q <= ctl_t'(ctl_wdata_i);
            irq_q <= (mf & ctl_q.irq_en) | (ovf & ctl_q.irq_en);
        end
    end

    ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (ssel_pin_i),
        .level_o (ss_level),
        .rise_o  (ss_rise)
    );

    mode_fault_det u_mf (
        .clk        (clk),
        .rst        (rst),
        .role_i     (role_i),
        .mf_en_i    (ctl_q.mf_en),
        .busy_i     (xfer_busy_i),
        .ss_level_i (ss_level),
        .ss_rise_i  (ss_rise),
        .stat_rd_i  (stat_rd_i),
        .ctl_wr_i   (ctl_wr_i),
        .mf_o       (mf)
    );

    rx_overflow_det #(.DW(DW)) u_ovf (
        .clk         (clk),
        .rst         (rst),
        .byte_done_i (byte_done_i),
        .rx_byte_i   (rx_byte_i),
        .data_rd_i   (data_rd_i),
        .stat_rd_i   (stat_rd_i),
        .rx_data_o   (rx_data_o),
        .ovf_o       (ovf)
    );

    always_comb begin
        stat.ovf = ovf;
        stat.mf  = mf;
        stat.ctl = ctl_q;
    end

    assign stat_o       = stat;
    assign mode_fault_o = mf;
    assign overflow_o   = ovf;
    assign err_irq_o    = irq_q;

    p_irq_gated_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(ctl_q.irq_en) |-> !irq_q);

    p_irq_raise_r10: assert property (@(posedge clk) disable iff (rst)
        ((mf || ovf) && ctl_q.irq_en) |=> irq_q);

endmodule

// File: tb/spi_fault_watch_tb.sv
module spi_fault_watch_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          role_i = 1'b0;
    logic          ssel_pin_i = 1'b1;
    logic          xfer_busy_i = 1'b0;
    logic          byte_done_i = 1'b0;
    logic [DW-1:0] rx_byte_i = '0;
    logic          data_rd_i = 1'b0;
    logic          stat_rd_i = 1'b0;
    logic          ctl_wr_i = 1'b0;
    logic [1:0]    ctl_wdata_i = '0;
    logic [3:0]    stat_o;
    logic [DW-1:0] rx_data_o;
    logic          mode_fault_o;
    logic          overflow_o;
    logic          err_irq_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    spi_fault_watch #(.DW(DW)) u_dut (
        .clk (clk), .rst (rst), .role_i (role_i), .ssel_pin_i (ssel_pin_i),
        .xfer_busy_i (xfer_busy_i), .byte_done_i (byte_done_i), .rx_byte_i (rx_byte_i),
        .data_rd_i (data_rd_i), .stat_rd_i (stat_rd_i), .ctl_wr_i (ctl_wr_i),
        .ctl_wdata_i (ctl_wdata_i), .stat_o (stat_o), .rx_data_o (rx_data_o),
        .mode_fault_o (mode_fault_o), .overflow_o (overflow_o), .err_irq_o (err_irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_ctl(input logic [1:0] d);
        ctl_wr_i = 1'b1; ctl_wdata_i = d;
        @(negedge clk);
        ctl_wr_i = 1'b0;
    endtask

    task automatic pulse_stat();
        stat_rd_i = 1'b1;
        @(negedge clk);
        stat_rd_i = 1'b0;
    endtask

    task automatic pulse_rd();
        data_rd_i = 1'b1;
        @(negedge clk);
        data_rd_i = 1'b0;
    endtask

    task automatic pulse_byte(input logic [DW-1:0] b, input logic with_rd);
        byte_done_i = 1'b1; rx_byte_i = b; data_rd_i = with_rd;
        @(negedge clk);
        byte_done_i = 1'b0; data_rd_i = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 mode fault", mode_fault_o, 0);
        check("R1 overflow", overflow_o, 0);
        check("R1 irq", err_irq_o, 0);
        check("R1 stat", stat_o, 0);
        check("R1 rx data", rx_data_o, 0);
    endtask

    task automatic t_fields();
        pulse_ctl(2'b01);
        check("R11 fault enable bit0", stat_o, 4'b0001);
        pulse_ctl(2'b10);
        check("R11 irq enable bit1", stat_o, 4'b0010);
        pulse_ctl(2'b00);
    endtask

    task automatic t_slave_latency();
        role_i = 1'b0;
        pulse_ctl(2'b01);
        ssel_pin_i = 1'b0;
        step(4);
        xfer_busy_i = 1'b1;
        ssel_pin_i = 1'b1;
        step(2);
        check("R2 flag not yet after two edges", mode_fault_o, 0);
        step(1);
        check("R2 R3 flag at third edge", mode_fault_o, 1);
        check("R11 mode fault bit2", stat_o, 4'b0101);
        xfer_busy_i = 1'b0;
        pulse_stat();
        pulse_ctl(2'b01);
        check("R8 clear after status read and write", mode_fault_o, 0);
    endtask

    task automatic t_slave_ignored();
        ssel_pin_i = 1'b0;
        step(4);
        ssel_pin_i = 1'b1;
        step(4);
        check("R3 idle rise ignored", mode_fault_o, 0);
        xfer_busy_i = 1'b1;
        ssel_pin_i = 1'b0;
        step(4);
        check("R3 fall during transfer ignored", mode_fault_o, 0);
        xfer_busy_i = 1'b0;
        ssel_pin_i = 1'b1;
        step(4);
    endtask

    task automatic t_enable_off();
        pulse_ctl(2'b00);
        xfer_busy_i = 1'b1;
        ssel_pin_i = 1'b0;
        step(4);
        ssel_pin_i = 1'b1;
        step(4);
        check("R5 slave rise while disabled", mode_fault_o, 0);
        xfer_busy_i = 1'b0;
        role_i = 1'b1;
        ssel_pin_i = 1'b0;
        step(4);
        check("R5 master low while disabled", mode_fault_o, 0);
        ssel_pin_i = 1'b1;
        step(4);
    endtask

    task automatic t_master();
        role_i = 1'b1;
        xfer_busy_i = 1'b0;
        pulse_ctl(2'b01);
        ssel_pin_i = 1'b0;
        step(3);
        check("R4 master low sets flag while idle", mode_fault_o, 1);
        ssel_pin_i = 1'b1;
        step(4);
        check("R4 flag stays after line high", mode_fault_o, 1);
        pulse_ctl(2'b01);
        check("R8 write without status read keeps flag", mode_fault_o, 1);
        pulse_stat();
        pulse_ctl(2'b01);
        check("R8 clear after handshake", mode_fault_o, 0);
        pulse_ctl(2'b00);
        role_i = 1'b0;
    endtask

    task automatic t_overflow();
        pulse_byte(8'hA5, 1'b0);
        check("R6 first byte loaded", rx_data_o, 8'hA5);
        check("R6 no overflow on first byte", overflow_o, 0);
        pulse_byte(8'h3C, 1'b0);
        check("R6 overflow set", overflow_o, 1);
        check("R6 older byte kept", rx_data_o, 8'hA5);
        pulse_rd();
        check("R9 read alone keeps flag", overflow_o, 1);
        pulse_stat();
        pulse_rd();
        check("R9 clear after handshake", overflow_o, 0);
    endtask

    task automatic t_same_cycle();
        pulse_byte(8'h11, 1'b0);
        pulse_byte(8'h22, 1'b1);
        check("R7 no overflow on read and load", overflow_o, 0);
        check("R7 new byte loaded", rx_data_o, 8'h22);
        pulse_rd();
    endtask

    task automatic t_irq();
        pulse_byte(8'h44, 1'b0);
        pulse_byte(8'h55, 1'b0);
        check("R10 flag without enable gives no irq", err_irq_o, 0);
        pulse_ctl(2'b10);
        check("R10 irq registered one cycle later", err_irq_o, 0);
        step(1);
        check("R10 irq raised", err_irq_o, 1);
        pulse_stat();
        pulse_rd();
        check("R10 flag cleared", overflow_o, 0);
        check("R10 irq still held one cycle", err_irq_o, 1);
        step(1);
        check("R10 irq dropped", err_irq_o, 0);
    endtask

    initial begin
        #1000000;
        n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_fields();
        t_slave_latency();
        t_slave_ignored();
        t_enable_off();
        t_master();
        t_overflow();
        t_same_cycle();
        t_irq();
        step(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule